// File: doc/BRIEF.md
# Two-Edge Wave Union Fine-Time Encoder

This block converts one clocked snapshot of a tapped delay line into a fine-time code for a wave union time measurement. On each hit, the launcher sends three edges into the line: two falling edges and one rising edge. The encoder finds the falling edges and ignores the rising one. It reports the sum of the two falling-edge tap positions. This sum is a code with twice the resolution of a single tap index, so one code step weighs half a tap.

The search is split into rows of taps. Each row finds its own lowest two falling edges. A merge stage then picks the lowest two over the whole line.

A small window tracker follows the enable signal. If the first snapshot in a window holds only one falling edge, because the other edge fell inside a wide bin, the encoder retries on the very next clock. If that retry snapshot holds two edges, the encoder reports the pair. If it does not, the encoder reports the held edge alone, doubled so that the code scale stays the same. The block gives at most one result per enable window.

Top module: `wu_pair_encoder`

## Requirements
- R1: A falling edge sits at tap index i (0 to N_TAPS-2) when bit i of the snapshot is 1 and bit i+1 is 0. A 0 followed by a 1 is a rising transition and is never counted or encoded.
- R2: A snapshot with two or more falling edges, accepted while the window is searching, gives the following one clock later: `code_vld` high for one cycle, `fine_code` equal to the sum of the two lowest falling-edge indices, and `single_edge` low.
- R3: With every result, `edge_cnt` reports how many falling edges the result snapshot held, saturating at 3.
- R4: A snapshot with exactly one falling edge produces no output on the following cycle. If the snapshot on the very next clock has two or more falling edges, that retry snapshot's pair code is reported one cycle after it.
- R5: If the retry clock brings no snapshot with two or more edges, or enable drops, the held edge is reported alone. In that case `single_edge` is 1, `fine_code` is twice the held index and `edge_cnt` is 1.
- R6: A snapshot with no falling edge pulses `no_hit` one cycle later, with `code_vld` low, and the window keeps searching.
- R7: The block gives at most one result per enable window. Snapshots after the result are ignored until enable goes low.
- R8: Snapshots presented while enable is low are ignored. They cause no `code_vld` and no `no_hit`.
- R9: After reset, `code_vld`, `no_hit`, `single_edge`, `edge_cnt` and `fine_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Hit window. While it is high, the edge pattern travels down the line |
| snap_vld | input | 1 | `taps` holds a snapshot this cycle |
| taps | input | N_TAPS | Delay-line state. Bit 0 is the tap nearest the launcher |
| code_vld | output | 1 | One-cycle strobe marking a new result |
| fine_code | output | $clog2(N_TAPS)+1 | Sum of two edge indices (half-tap weight) |
| single_edge | output | 1 | Result was built from one edge, doubled |
| edge_cnt | output | 2 | Falling edges in the result snapshot, saturated at 3 |
| no_hit | output | 1 | One-cycle strobe: an accepted snapshot held no falling edge |

## Verification
The bench uses a 12-tap line split into three rows of four taps. It drives every one of the 4096 possible snapshots as the first snapshot of a window. This covers patterns with zero, one, two and many falling edges, edges on row boundaries, and any mix of rising transitions.

The patterns with exactly one edge alternate between two retry cases: a two-edge retry snapshot and no retry snapshot. This separates the pair path of the retry from the doubled single-edge path.

Each window then tries a further snapshot after its result and a snapshot with enable low. These show that both are dropped. A zero-edge start is followed by a good snapshot, which shows that the window is still searching. A directed case drops enable while one edge is held.

// File: rtl/wu_enc_pkg.sv
package wu_enc_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_HOLD   = 2'd1,
    ST_DONE   = 2'd2
  } wu_state_e;

  // Saturating add of two edge counts (3 means three or more)
  function automatic logic [1:0] sat_cnt_add(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > 3'd3) ? 2'd3 : s[1:0];
  endfunction

endpackage

// File: rtl/wu_fall_mark.sv
module wu_fall_mark #(
  parameter int N = 1024
) (
  input  logic [N-1:0] taps,
  output logic [N-1:0] fall_mark
);

  // Mark i is set where a 1 is followed by a 0 one tap further down the line
  for (genvar i = 0; i < N - 1; i++) begin : g_mark
    assign fall_mark[i] = taps[i] & ~taps[i+1];
  end
  assign fall_mark[N-1] = 1'b0;

endmodule

// File: rtl/wu_row_scan.sv
module wu_row_scan #(
  parameter int ROW_W    = 128,
  parameter int IDX_W    = 10,
  parameter int ROW_BASE = 0
) (
  input  logic [ROW_W-1:0] mark,
  output logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] second_idx,
  output logic [1:0]       cnt
);

  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    cnt        = 2'd0;
    for (int j = 0; j < ROW_W; j++) begin
      if (mark[j]) begin
        if (cnt == 2'd0) begin
          first_idx = IDX_W'(ROW_BASE + j);
        end else if (cnt == 2'd1) begin
          second_idx = IDX_W'(ROW_BASE + j);
        end
        if (cnt != 2'd3) begin
          cnt = cnt + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/wu_pair_pick.sv
module wu_pair_pick #(
  parameter int ROWS  = 8,
  parameter int IDX_W = 10
) (
  input  logic [ROWS-1:0][IDX_W-1:0] row_first,
  input  logic [ROWS-1:0][IDX_W-1:0] row_second,
  input  logic [ROWS-1:0][1:0]       row_cnt,
  output logic [IDX_W-1:0]           idx_a,
  output logic [IDX_W-1:0]           idx_b,
  output logic [1:0]                 total_cnt
);
  import wu_enc_pkg::*;

  // Rows are walked from the launcher end, so the first two found are the lowest
  always_comb begin
    idx_a     = '0;
    idx_b     = '0;
    total_cnt = 2'd0;
    for (int r = 0; r < ROWS; r++) begin
      if (total_cnt == 2'd0) begin
        if (row_cnt[r] != 2'd0) idx_a = row_first[r];
        if (row_cnt[r] >= 2'd2) idx_b = row_second[r];
      end else if (total_cnt == 2'd1) begin
        if (row_cnt[r] != 2'd0) idx_b = row_first[r];
      end
      total_cnt = sat_cnt_add(total_cnt, row_cnt[r]);
    end
  end

endmodule

// File: rtl/wu_pair_encoder.sv
module wu_pair_encoder #(
  parameter int N_TAPS = 1024,
  parameter int ROWS   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        snap_vld,
  input  logic [N_TAPS-1:0]           taps,
  output logic                        code_vld,
  output logic [$clog2(N_TAPS):0]     fine_code,
  output logic                        single_edge,
  output logic [1:0]                  edge_cnt,
  output logic                        no_hit
);
  import wu_enc_pkg::*;

  localparam int ROW_W  = N_TAPS / ROWS;
  localparam int IDX_W  = $clog2(N_TAPS);
  localparam int CODE_W = IDX_W + 1;

  // ---------------- transition search ----------------
  logic [N_TAPS-1:0]          fall_mark;
  logic [ROWS-1:0][IDX_W-1:0] row_first;
  logic [ROWS-1:0][IDX_W-1:0] row_second;
  logic [ROWS-1:0][1:0]       row_cnt;
  logic [IDX_W-1:0]           idx_a;
  logic [IDX_W-1:0]           idx_b;
  logic [1:0]                 tot_cnt;

  wu_fall_mark #(.N(N_TAPS)) u_mark (
    .taps      (taps),
    .fall_mark (fall_mark)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    wu_row_scan #(
      .ROW_W    (ROW_W),
      .IDX_W    (IDX_W),
      .ROW_BASE (r * ROW_W)
    ) u_scan (
      .mark       (fall_mark[r*ROW_W +: ROW_W]),
      .first_idx  (row_first[r]),
      .second_idx (row_second[r]),
      .cnt        (row_cnt[r])
    );
  end

  wu_pair_pick #(.ROWS(ROWS), .IDX_W(IDX_W)) u_pick (
    .row_first  (row_first),
    .row_second (row_second),
    .row_cnt    (row_cnt),
    .idx_a      (idx_a),
    .idx_b      (idx_b),
    .total_cnt  (tot_cnt)
  );

  // ---------------- window tracker ----------------
  wu_state_e         st_q, st_d;
  logic [IDX_W-1:0]  held_q, held_d;
  logic              held_en;
  logic              snap_acc;
  logic              emit_d, nohit_d, single_d;
  logic [CODE_W-1:0] code_d;
  logic [1:0]        cnt_d;
  logic              res_en;

  logic              vld_q, nohit_q, single_q;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        cnt_q;

  assign snap_acc = enable & snap_vld;

  always_comb begin
    st_d     = st_q;
    held_d   = held_q;
    held_en  = 1'b0;
    emit_d   = 1'b0;
    nohit_d  = 1'b0;
    single_d = 1'b0;
    code_d   = CODE_W'(idx_a) + CODE_W'(idx_b);
    cnt_d    = tot_cnt;
    unique case (st_q)
      ST_SEARCH: begin
        if (snap_acc) begin
          if (tot_cnt >= 2'd2) begin
            emit_d = 1'b1;
            st_d   = ST_DONE;
          end else if (tot_cnt == 2'd1) begin
            held_d  = idx_a;
            held_en = 1'b1;
            st_d    = ST_HOLD;
          end else begin
            nohit_d = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        emit_d = 1'b1;
        if (!(snap_acc && tot_cnt >= 2'd2)) begin
          single_d = 1'b1;
          code_d   = {held_q, 1'b0};
          cnt_d    = 2'd1;
        end
        st_d = enable ? ST_DONE : ST_SEARCH;
      end
      ST_DONE: begin
        if (!enable) st_d = ST_SEARCH;
      end
      default: st_d = ST_SEARCH;
    endcase
  end

  assign res_en = emit_d | nohit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      held_q <= '0;
    end else begin
      st_q <= st_d;
      if (held_en) held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      nohit_q  <= 1'b0;
      single_q <= 1'b0;
      code_q   <= '0;
      cnt_q    <= 2'd0;
    end else begin
      vld_q   <= emit_d;
      nohit_q <= nohit_d;
      if (res_en) begin
        single_q <= single_d;
        code_q   <= emit_d ? code_d : '0;
        cnt_q    <= emit_d ? cnt_d : 2'd0;
      end
    end
  end

  assign code_vld    = vld_q;
  assign no_hit      = nohit_q;
  assign single_edge = single_q;
  assign fine_code   = code_q;
  assign edge_cnt    = cnt_q;

  // ---------------- assertions ----------------
  a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_acc && st_q == ST_SEARCH && tot_cnt >= 2'd2) |-> (idx_a < idx_b));

  a_r2_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_vld) |-> $past(snap_acc || st_q == ST_HOLD));

  a_r4_hold_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |=> code_vld);

  a_r5_single_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && single_edge) |-> (edge_cnt == 2'd1 && fine_code[0] == 1'b0));

  a_r6_nohit_excl: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit |-> !code_vld);

  a_r7_one_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> !code_vld);

  a_r8_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && st_q != ST_HOLD) |=> (!code_vld && !no_hit));

endmodule

// File: tb/wu_pair_encoder_tb.sv
module wu_pair_encoder_tb_top;

  localparam int N      = 12;
  localparam int ROWS   = 3;
  localparam int CODE_W = $clog2(N) + 1;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] Q_PAT = 12'b0000_0011_0011;

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic snap_vld;
  logic [N-1:0] taps;
  logic code_vld;
  logic [CODE_W-1:0] fine_code;
  logic single_edge;
  logic [1:0] edge_cnt;
  logic no_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wu_pair_encoder #(.N_TAPS(N), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .snap_vld(snap_vld), .taps(taps),
    .code_vld(code_vld), .fine_code(fine_code), .single_edge(single_edge),
    .edge_cnt(edge_cnt), .no_hit(no_hit)
  );

  // Independent reference: falling edge at i when bit i is 1 and bit i+1 is 0
  function automatic void model(input logic [N-1:0] p, output int c, output int a, output int b);
    c = 0; a = 0; b = 0;
    for (int i = 0; i < N - 1; i++) begin
      if (p[i] && !p[i+1]) begin
        if (c == 0) a = i;
        else if (c == 1) b = i;
        c++;
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pair(input string req, input int a, input int b, input int c);
    chk(code_vld == 1'b1, req, int'(code_vld), 1);
    chk(int'(fine_code) == a + b, req, int'(fine_code), a + b);
    chk(single_edge == 1'b0, req, int'(single_edge), 0);
    chk(int'(edge_cnt) == ((c > 3) ? 3 : c), {req, " R3"}, int'(edge_cnt), (c > 3) ? 3 : c);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int c, a, b, qc, qa, qb;
    rst_n = 1'b0; enable = 1'b0; snap_vld = 1'b0; taps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset values
    chk(code_vld == 1'b0 && no_hit == 1'b0, "R9", int'(code_vld) + int'(no_hit), 0);
    chk(fine_code == '0 && edge_cnt == 2'd0 && single_edge == 1'b0, "R9", int'(fine_code), 0);

    model(Q_PAT, qc, qa, qb);

    for (int p = 0; p < (1 << N); p++) begin
      model(N'(p), c, a, b);
      enable = 1'b1; snap_vld = 1'b1; taps = N'(p);
      step();
      if (c >= 2) begin
        chk_pair("R1,R2", a, b, c);
        taps = Q_PAT;                       // R7: later snapshot dropped
        step();
        chk(code_vld == 1'b0, "R7", int'(code_vld), 0);
      end else if (c == 0) begin
        chk(no_hit == 1'b1 && code_vld == 1'b0, "R6", int'(no_hit), 1);
        taps = Q_PAT;                       // R6: window still searching
        step();
        chk_pair("R6", qa, qb, qc);
      end else begin
        chk(code_vld == 1'b0 && no_hit == 1'b0, "R4", int'(code_vld), 0);
        if (p[0]) begin
          taps = Q_PAT;
          step();
          chk_pair("R4", qa, qb, qc);
        end else begin
          snap_vld = 1'b0;
          step();
          chk(code_vld == 1'b1 && single_edge == 1'b1, "R5", int'(single_edge), 1);
          chk(int'(fine_code) == 2 * a, "R5", int'(fine_code), 2 * a);
          chk(edge_cnt == 2'd1, "R5", int'(edge_cnt), 1);
        end
      end
      // R8: window closed, snapshot ignored
      enable = 1'b0; snap_vld = 1'b1; taps = Q_PAT;
      step();
      chk(code_vld == 1'b0 && no_hit == 1'b0, "R8", int'(code_vld) + int'(no_hit), 0);
      snap_vld = 1'b0;
      step();
    end

    // R5: enable drops while one edge is held (edge at tap 4, rising at 1 ignored)
    enable = 1'b1; snap_vld = 1'b1; taps = 12'b0000_0001_1100;
    step();
    chk(code_vld == 1'b0, "R5", int'(code_vld), 0);
    enable = 1'b0; snap_vld = 1'b0;
    step();
    chk(code_vld == 1'b1 && single_edge == 1'b1, "R5", int'(single_edge), 1);
    chk(int'(fine_code) == 8, "R5", int'(fine_code), 8);
    step();
    chk(code_vld == 1'b0, "R7", int'(code_vld), 0);

    finish_run();
  end

endmodule